// File: doc/BRIEF.md
# Eight-Input Interrupt Controller Register Port

This block gathers eight interrupt request lines and gives a processor one interrupt output, through a register port with two addresses. A one-bit address picks the command location (0) or the data location (1). After reset the processor writes a short setup sequence. One command word opens the sequence. Two or three data words follow: a vector base, an optional cascade map and an optional mode word. Until the sequence ends the block raises no interrupt.

Once set up, data writes load the mask. Command writes either retire the current highest in-service level or choose which register later command reads return: pending requests or levels in service. A rising edge on an input latches a request. The interrupt output rises when an unmasked request outranks every level in service, and input 0 ranks highest. An acknowledge pulse moves the winning request into service. It also publishes an 8-bit vector built from the base and the input number. The cascade map and the mode bit are held and brought out unchanged for the surrounding logic.

Top module: `intc8_regport`

## Requirements
- R1: After reset, reads of either address return 0x00, `intOut` is low and `vecOut` is 0x00.
- R2: A command write with data bit 4 set restarts setup. It clears the request, in-service and mask registers and points command reads at the request register. `intOut` stays low until setup completes. In that word, bit 1 = 1 means single (no cascade word) and bit 0 = 1 means a mode word follows.
- R3: After the restart word, data writes are taken in this order: vector base, then the cascade map (only when bit 1 was 0), then the mode word (only when bit 0 was 1, mode bit = data bit 0). The block is then ready and later data writes load the mask.
- R4: Before the first restart word, data writes and the bit-4-clear command words have no effect.
- R5: When ready, a data write loads the mask (bit n = 1 masks input n). A data read always returns the mask.
- R6: A rising edge on `irqIn[n]` sets request bit n. A line held high does not set the bit again once it is cleared.
- R7: `intOut` is high exactly when the block is ready and some unmasked request has a lower index than the lowest set in-service bit (or nothing is in service).
- R8: `ackIn` while `intOut` is high moves the lowest-index unmasked request from request to in-service. On the next cycle `vecOut` = {base[7:3], index}. `ackIn` while `intOut` is low changes nothing.
- R9: When ready, a command write with bits[4:3] = 00 and bits[7:5] = 001 (e.g. 0x20) clears the lowest-index in-service bit. Other values with bits[4:3] = 00 are ignored.
- R10: When ready, a command write with bits[4:3] = 01 changes the read selection. Bits[1:0] = 10 selects the request register, 11 selects the in-service register, and 0x leaves it unchanged. Command reads return the selected register.
- R11: With all inputs masked `intOut` stays low, yet edges still set request bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| addr | input | 1 | 0 = command location, 1 = data location |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current `addr` (combinational) |
| irqIn | input | 8 | Interrupt request lines, edge sensitive |
| ackIn | input | 1 | Acknowledge pulse |
| intOut | output | 1 | Interrupt to the processor |
| vecOut | output | 8 | Vector of the last granted acknowledge |
| cascadeCfg | output | 8 | Stored cascade map |
| mode86 | output | 1 | Stored mode bit |

## Verification
The bench walks full setup sequences of both lengths and checks that a data word written before setup leaves the mask untouched. If the sequencer miscounted words, the base would land in the mask or the vector would come out wrong. The nested case is covered: an in-service level 3 must block a level-5 request but not a level-1 request. A wrong priority compare would raise or hide the interrupt there. The bench also covers a non-matching end-of-interrupt word, a no-change read-select word, an acknowledge with nothing eligible, and a line held high across its own acknowledge. A design that re-latched levels or honoured those words would show different register contents on readback.

// File: rtl/intc8_pkg.sv
package intc8_pkg;

  // Strobes from the sequencer to the register datapath
  typedef struct packed {
    logic clrAll;     // restart: clear request, service, mask, selection
    logic ldBase;     // load vector base
    logic ldCascade;  // load cascade map
    logic ldMode;     // load mode bit
    logic ldMask;     // load mask
    logic setSel;     // update read selection
    logic selIsr;     // new selection value (1 = in-service)
    logic eoi;        // retire lowest-index in-service bit
  } ctlStrobe_t;

endpackage

// File: rtl/intc8_ctrl.sv
module intc8_ctrl
  import intc8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output ctlStrobe_t        strobe,
  output logic              ready
);

  typedef enum logic [2:0] {
    ST_UNINIT,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_READY
  } seqState_t;

  seqState_t state, stateNext;
  logic needMode;
  logic singleMode;
  logic startWord;
  logic unusedCtlBits;

  assign unusedCtlBits = ^{wrData[DATA_W-1:8], wrData[2]};
  assign startWord = wrEn && !addr && wrData[4];

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (startWord) begin
      strobe.clrAll = 1'b1;
      stateNext     = ST_BASE;
    end else if (wrEn && addr) begin
      unique case (state)
        ST_BASE: begin
          strobe.ldBase = 1'b1;
          if (!singleMode)   stateNext = ST_CASC;
          else if (needMode) stateNext = ST_MODE;
          else               stateNext = ST_READY;
        end
        ST_CASC: begin
          strobe.ldCascade = 1'b1;
          stateNext = needMode ? ST_MODE : ST_READY;
        end
        ST_MODE: begin
          strobe.ldMode = 1'b1;
          stateNext     = ST_READY;
        end
        ST_READY: strobe.ldMask = 1'b1;
        default: ;
      endcase
    end else if (wrEn && !addr && state == ST_READY) begin
      if (wrData[3]) begin
        if (wrData[1]) begin
          strobe.setSel = 1'b1;
          strobe.selIsr = wrData[0];
        end
      end else if (wrData[7:5] == 3'b001) begin
        strobe.eoi = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_UNINIT;
      needMode   <= 1'b0;
      singleMode <= 1'b0;
    end else begin
      state <= stateNext;
      if (startWord) begin
        needMode   <= wrData[0];
        singleMode <= wrData[1];
      end
    end
  end

  assign ready = (state == ST_READY);

endmodule

// File: rtl/intc8_dp.sv
module intc8_dp
  import intc8_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic               ready,
  input  logic [NUM_IRQ-1:0] wrData,
  input  logic               addr,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               ackIn,
  output logic [NUM_IRQ-1:0] rdData,
  output logic               intOut,
  output logic [NUM_IRQ-1:0] vecOut,
  output logic [NUM_IRQ-1:0] cascadeCfg,
  output logic               mode86,
  output logic [NUM_IRQ-1:0] irrQ,
  output logic [NUM_IRQ-1:0] isrQ,
  output logic [NUM_IRQ-1:0] maskQ
);

  localparam int IDX_W  = $clog2(NUM_IRQ);
  localparam int BASE_W = NUM_IRQ - IDX_W;

  logic [NUM_IRQ-1:0] irqPrev;
  logic [NUM_IRQ-1:0] edgeSeen;
  logic [NUM_IRQ-1:0] pending;
  logic [NUM_IRQ-1:0] grantOh;
  logic [NUM_IRQ-1:0] eoiOh;
  logic [IDX_W-1:0]   winIdx;
  logic [IDX_W-1:0]   svcIdx;
  logic [BASE_W-1:0]  baseHi;
  logic               haveReq;
  logic               svcAny;
  logic               readIsr;
  logic               grant;

  assign edgeSeen = irqIn & ~irqPrev;
  assign pending  = irrQ & ~maskQ;
  assign haveReq  = |pending;
  assign svcAny   = |isrQ;

  // Lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    winIdx = '0;
    svcIdx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pending[i]) winIdx = IDX_W'(i);
      if (isrQ[i])    svcIdx = IDX_W'(i);
    end
  end

  assign intOut  = ready && haveReq && (!svcAny || (winIdx < svcIdx));
  assign grant   = ackIn && intOut;
  assign grantOh = grant ? (NUM_IRQ'(1) << winIdx) : '0;
  assign eoiOh   = (strobe.eoi && svcAny) ? (NUM_IRQ'(1) << svcIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrev <= '0;
      irrQ    <= '0;
      isrQ    <= '0;
      maskQ   <= '0;
      readIsr <= 1'b0;
      vecOut  <= '0;
    end else begin
      irqPrev <= irqIn;
      if (strobe.clrAll) begin
        irrQ    <= '0;
        isrQ    <= '0;
        maskQ   <= '0;
        readIsr <= 1'b0;
      end else begin
        irrQ <= (irrQ & ~grantOh) | edgeSeen;
        isrQ <= (isrQ | grantOh) & ~eoiOh;
        if (strobe.ldMask) maskQ   <= wrData;
        if (strobe.setSel) readIsr <= strobe.selIsr;
      end
      if (grant) vecOut <= {baseHi, winIdx};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi     <= '0;
      cascadeCfg <= '0;
      mode86     <= 1'b0;
    end else begin
      if (strobe.ldBase)    baseHi     <= wrData[NUM_IRQ-1:IDX_W];
      if (strobe.ldCascade) cascadeCfg <= wrData;
      if (strobe.ldMode)    mode86     <= wrData[0];
    end
  end

  assign rdData = addr ? maskQ : (readIsr ? isrQ : irrQ);

endmodule

// File: rtl/intc8_regport.sv
module intc8_regport
  import intc8_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               addr,
  input  logic [NUM_IRQ-1:0] wrData,
  output logic [NUM_IRQ-1:0] rdData,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               ackIn,
  output logic               intOut,
  output logic [NUM_IRQ-1:0] vecOut,
  output logic [NUM_IRQ-1:0] cascadeCfg,
  output logic               mode86
);

  ctlStrobe_t         strobeW;
  logic               readyW;
  logic [NUM_IRQ-1:0] irrW;
  logic [NUM_IRQ-1:0] isrW;
  logic [NUM_IRQ-1:0] maskW;

  intc8_ctrl #(.DATA_W(NUM_IRQ)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .strobe (strobeW),
    .ready  (readyW)
  );

  intc8_dp #(.NUM_IRQ(NUM_IRQ)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobeW),
    .ready      (readyW),
    .wrData     (wrData),
    .addr       (addr),
    .irqIn      (irqIn),
    .ackIn      (ackIn),
    .rdData     (rdData),
    .intOut     (intOut),
    .vecOut     (vecOut),
    .cascadeCfg (cascadeCfg),
    .mode86     (mode86),
    .irrQ       (irrW),
    .isrQ       (isrW),
    .maskQ      (maskW)
  );

endmodule

// File: rtl/intc8_chk.sv
module intc8_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       addr,
  input logic [7:0] wrData,
  input logic       ackIn,
  input logic       intOut,
  input logic [7:0] vecOut,
  input logic       readyW,
  input logic [7:0] irrW,
  input logic [7:0] isrW,
  input logic [7:0] maskW
);

  // R2
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[4]) |=> (irrW == 8'h00 && isrW == 8'h00 && maskW == 8'h00));

  // R2
  no_int_unready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readyW |-> !intOut);

  // R11
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskW == 8'hFF) |-> !intOut);

  // R8
  ack_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && intOut && !(wrEn && !addr)) |=> ($countones(isrW) == $past($countones(isrW)) + 1));

  // R8
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !intOut) |=> $stable(vecOut));

  // R9
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData == 8'h20 && readyW && isrW != 8'h00 && !ackIn)
      |=> ($countones(isrW) == $past($countones(isrW)) - 1));

endmodule

bind intc8_regport intc8_chk u_chk (.*);

// File: tb/intc8_regport_tb.sv
`timescale 1ns/1ps
module intc8_regport_tb;

  localparam int OP_WR  = 0;
  localparam int OP_RD  = 1;
  localparam int OP_INT = 2;
  localparam int OP_IRQ = 3;
  localparam int OP_ACK = 4;
  localparam int OP_VEC = 5;
  localparam int NV     = 63;
  localparam int WDOG   = 100000;

  typedef struct packed {
    logic [2:0] op;
    logic       a;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] req;
  } step_t;

  localparam step_t TBL [NV] = '{
    '{3'd1, 1'b0, 8'h00, 8'h00, 4'd1},  // R1 command read after reset
    '{3'd1, 1'b1, 8'h00, 8'h00, 4'd1},  // R1 data read after reset
    '{3'd2, 1'b0, 8'h00, 8'h00, 4'd1},  // R1 no interrupt
    '{3'd5, 1'b0, 8'h00, 8'h00, 4'd1},  // R1 vector clear
    '{3'd0, 1'b1, 8'h5A, 8'h00, 4'd4},  // R4 data write before setup
    '{3'd1, 1'b1, 8'h00, 8'h00, 4'd4},  // R4 mask untouched
    '{3'd0, 1'b0, 8'h11, 8'h00, 4'd2},  // R2 restart, cascade, mode word
    '{3'd0, 1'b1, 8'h40, 8'h00, 4'd3},  // R3 base
    '{3'd0, 1'b1, 8'h04, 8'h00, 4'd3},  // R3 cascade map
    '{3'd0, 1'b1, 8'h01, 8'h00, 4'd3},  // R3 mode word
    '{3'd0, 1'b1, 8'hF0, 8'h00, 4'd5},  // R5 mask load
    '{3'd1, 1'b1, 8'h00, 8'hF0, 4'd5},  // R5 mask readback
    '{3'd3, 1'b0, 8'h20, 8'h00, 4'd6},  // R6 edge on 5
    '{3'd1, 1'b0, 8'h00, 8'h20, 4'd6},  // R6 request latched
    '{3'd2, 1'b0, 8'h00, 8'h00, 4'd11}, // R11 masked, no interrupt
    '{3'd3, 1'b0, 8'h28, 8'h00, 4'd6},  // R6 edge on 3
    '{3'd2, 1'b0, 8'h00, 8'h01, 4'd7},  // R7 interrupt raised
    '{3'd4, 1'b0, 8'h00, 8'h00, 4'd8},  // R8 acknowledge
    '{3'd5, 1'b0, 8'h00, 8'h43, 4'd8},  // R8 vector base|3
    '{3'd1, 1'b0, 8'h00, 8'h20, 4'd8},  // R8 request 3 cleared
    '{3'd0, 1'b0, 8'h0B, 8'h00, 4'd10}, // R10 select in-service
    '{3'd1, 1'b0, 8'h00, 8'h08, 4'd10}, // R10 in-service readback
    '{3'd0, 1'b0, 8'h08, 8'h00, 4'd10}, // R10 no-change selection word
    '{3'd1, 1'b0, 8'h00, 8'h08, 4'd10}, // R10 still in-service
    '{3'd0, 1'b1, 8'h00, 8'h00, 4'd5},  // R5 unmask all
    '{3'd2, 1'b0, 8'h00, 8'h00, 4'd7},  // R7 level 5 blocked by 3
    '{3'd3, 1'b0, 8'h2A, 8'h00, 4'd6},  // R6 edge on 1
    '{3'd2, 1'b0, 8'h00, 8'h01, 4'd7},  // R7 level 1 nests over 3
    '{3'd4, 1'b0, 8'h00, 8'h00, 4'd8},  // R8 acknowledge
    '{3'd5, 1'b0, 8'h00, 8'h41, 4'd8},  // R8 vector base|1
    '{3'd1, 1'b0, 8'h00, 8'h0A, 4'd8},  // R8 in-service 1 and 3
    '{3'd0, 1'b0, 8'h60, 8'h00, 4'd9},  // R9 non-matching word
    '{3'd1, 1'b0, 8'h00, 8'h0A, 4'd9},  // R9 ignored
    '{3'd0, 1'b0, 8'h20, 8'h00, 4'd9},  // R9 end of interrupt
    '{3'd1, 1'b0, 8'h00, 8'h08, 4'd9},  // R9 bit 1 retired
    '{3'd2, 1'b0, 8'h00, 8'h00, 4'd7},  // R7 5 still blocked
    '{3'd0, 1'b0, 8'h20, 8'h00, 4'd9},  // R9 end of interrupt
    '{3'd1, 1'b0, 8'h00, 8'h00, 4'd9},  // R9 bit 3 retired
    '{3'd2, 1'b0, 8'h00, 8'h01, 4'd7},  // R7 5 now eligible
    '{3'd0, 1'b1, 8'hFF, 8'h00, 4'd11}, // R11 mask all
    '{3'd2, 1'b0, 8'h00, 8'h00, 4'd11}, // R11 quiet
    '{3'd0, 1'b0, 8'h0A, 8'h00, 4'd10}, // R10 select request
    '{3'd1, 1'b0, 8'h00, 8'h20, 4'd10}, // R10 request readback
    '{3'd4, 1'b0, 8'h00, 8'h00, 4'd8},  // R8 acknowledge with no interrupt
    '{3'd5, 1'b0, 8'h00, 8'h41, 4'd8},  // R8 vector unchanged
    '{3'd1, 1'b0, 8'h00, 8'h20, 4'd8},  // R8 request unchanged
    '{3'd0, 1'b0, 8'h0B, 8'h00, 4'd10}, // R10 select in-service
    '{3'd0, 1'b0, 8'h12, 8'h00, 4'd2},  // R2 restart, single, no mode
    '{3'd1, 1'b1, 8'h00, 8'h00, 4'd2},  // R2 mask cleared
    '{3'd1, 1'b0, 8'h00, 8'h00, 4'd2},  // R2 request cleared
    '{3'd3, 1'b0, 8'h2B, 8'h00, 4'd6},  // R6 edge on 0
    '{3'd1, 1'b0, 8'h00, 8'h01, 4'd2},  // R2 selection back to request
    '{3'd2, 1'b0, 8'h00, 8'h00, 4'd2},  // R2 held low during setup
    '{3'd0, 1'b1, 8'h80, 8'h00, 4'd3},  // R3 base, setup done
    '{3'd2, 1'b0, 8'h00, 8'h01, 4'd3},  // R3 ready
    '{3'd4, 1'b0, 8'h00, 8'h00, 4'd3},  // R3 acknowledge
    '{3'd5, 1'b0, 8'h00, 8'h80, 4'd3},  // R3 new base in vector
    '{3'd1, 1'b0, 8'h00, 8'h00, 4'd6},  // R6 held line not relatched
    '{3'd0, 1'b1, 8'h33, 8'h00, 4'd3},  // R3 next data word is mask
    '{3'd1, 1'b1, 8'h00, 8'h33, 4'd3},  // R3 mask readback
    '{3'd3, 1'b0, 8'h2A, 8'h00, 4'd6},  // R6 drop line 0
    '{3'd3, 1'b0, 8'h2B, 8'h00, 4'd6},  // R6 raise line 0
    '{3'd1, 1'b0, 8'h00, 8'h01, 4'd6}   // R6 relatched
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] irqIn = 8'h00;
  logic       ackIn = 1'b0;
  logic [7:0] rdData;
  logic       intOut;
  logic [7:0] vecOut;
  logic [7:0] cascadeCfg;
  logic       mode86;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  intc8_regport u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .rdData     (rdData),
    .irqIn      (irqIn),
    .ackIn      (ackIn),
    .intOut     (intOut),
    .vecOut     (vecOut),
    .cascadeCfg (cascadeCfg),
    .mode86     (mode86)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WDOG) begin
      testsFailed++;
      $display("FAIL watchdog: got %0d cycles exp < %0d", cycles, WDOG);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp, input string what);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL R%0d %s: got %02h exp %02h", req, what, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      addr = TBL[k].a;
      case (int'(TBL[k].op))
        OP_WR:  begin wrEn = 1'b1; wrData = TBL[k].d; end
        OP_IRQ: irqIn = TBL[k].d;
        OP_ACK: ackIn = 1'b1;
        default: ;
      endcase
      @(negedge clk);
      wrEn  = 1'b0;
      ackIn = 1'b0;
      case (int'(TBL[k].op))
        OP_RD:  check(int'(TBL[k].req), rdData, TBL[k].e, "read");
        OP_INT: check(int'(TBL[k].req), {7'b0, intOut}, TBL[k].e, "intOut");
        OP_VEC: check(int'(TBL[k].req), vecOut, TBL[k].e, "vector");
        default: ;
      endcase
    end

    // R3: stored cascade map and mode bit from the first setup pass
    check(3, cascadeCfg, 8'h04, "cascade map");
    check(3, {7'b0, mode86}, 8'h01, "mode bit");

    // R1: reset in mid-operation returns everything to the idle state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    addr = 1'b0;
    #1 check(1, rdData, 8'h00, "command read in reset");
    addr = 1'b1;
    #1 check(1, rdData, 8'h00, "data read in reset");
    check(1, {7'b0, intOut}, 8'h00, "intOut in reset");
    check(1, vecOut, 8'h00, "vector in reset");
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule